// File: doc/BRIEF.md
# Decaying Open-Bus Data Latch

This block holds the byte that most recently crossed a peripheral's register port, whether it was read or written. Later reads of unmapped or write-only locations can return it. Each stored 1 has its own age timer. A bit that has gone unrefreshed for longer than a fixed number of pixel-clock ticks reads back as 0. The stored byte itself is kept unchanged.

The surrounding logic pulses `load` with the byte seen on the port. A plain load restarts the timer of every bit that is 1 in the new byte. A masked load restarts only the bits that are 1 in both the byte and `refresh_mask`. In a masked load, the other bits take their new value but keep their old age. `tick_en` pulses once per pixel clock and ages every bit.

Top module: `decay_latch`

## Requirements
- R1: Reset clears the stored byte and every per-bit timer. After reset `bus_q` is 0x00, and a masked load with an all-zero mask then still reads 0x00.
- R2: A plain load (`load`=1, `use_mask`=0) makes `bus_q` equal `load_data` from the next clock.
- R3: A bit stored as 0 reads 0 regardless of its timer.
- R4: After a refresh, a bit stored as 1 reads 1 through exactly HOLD_TICKS further ticks. It reads 0 once HOLD_TICKS+1 ticks have passed.
- R5: Bits refreshed at different times decay independently, each at its own HOLD_TICKS+1 boundary.
- R6: A masked load (`use_mask`=1) stores the whole byte but restarts timers only where both `load_data` and `refresh_mask` are 1. A stored 1 whose timer has expired and was not restarted reads 0.
- R7: When a load and a tick fall in the same cycle, refreshed bits start a full HOLD_TICKS interval and ignore that tick, while bits that were not refreshed still age by it.
- R8: Without `tick_en` and without `load`, `bus_q` holds its value indefinitely.
- R9: Loading a 1 again into a bit that already reads 1 restarts its interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One pulse per pixel clock; ages all bits |
| load | input | 1 | Store `load_data` this cycle |
| load_data | input | WIDTH | Byte seen on the register port |
| use_mask | input | 1 | Restrict timer restart to `refresh_mask` |
| refresh_mask | input | WIDTH | Bits allowed to restart on a masked load |
| bus_q | output | WIDTH | Stored byte with expired bits forced to 0 |

## Verification
The hardest case to reach is a byte in which some bits are stored as 1 but carry an expired timer or one of a different age. In that case the output differs from the stored byte. The bench reaches it with a masked load over bits that aged part way. It then ticks to the exact boundary of each group. A masked load with an empty mask after reset shows that the timers were cleared as well as the byte.

// File: rtl/decay_latch.sv
module decay_latch #(
  parameter int WIDTH      = 8,
  parameter int HOLD_TICKS = 3216312
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             use_mask,
  input  logic [WIDTH-1:0] refresh_mask,
  output logic [WIDTH-1:0] bus_q
);
  localparam int CW = $clog2(HOLD_TICKS + 2);
  localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS + 1);

  logic [WIDTH-1:0] held;
  logic [WIDTH-1:0] alive;
  wire  [WIDTH-1:0] gate  = use_mask ? refresh_mask : {WIDTH{1'b1}};
  wire  [WIDTH-1:0] renew = {WIDTH{load}} & load_data & gate;

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= load_data;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [CW-1:0] left;
    always_ff @(posedge clk) begin
      if (!rst_n)                        left <= '0;
      else if (renew[i])                 left <= FULL;
      else if (tick_en && left != '0)    left <= left - 1'b1;
    end
    assign alive[i] = (left != '0);
  end

  assign bus_q = held & alive;
endmodule

module decay_latch_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             load,
  input logic [WIDTH-1:0] load_data,
  input logic             use_mask,
  input logic [WIDTH-1:0] refresh_mask,
  input logic [WIDTH-1:0] bus_q
);
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bus_q == '0);

  p_plain_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !use_mask) |=> bus_q == $past(load_data));

  p_masked_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && use_mask) |=>
      (bus_q & $past(load_data & refresh_mask)) == $past(load_data & refresh_mask));

  p_masked_no_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && use_mask) |=> (bus_q & ~$past(load_data)) == '0);

  p_no_rise_without_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (bus_q & ~$past(bus_q)) == '0);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick_en) |=> $stable(bus_q));
endmodule

bind decay_latch decay_latch_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/decay_latch_tb.sv
module decay_latch_tb;
  localparam int T = 20;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick_en = 0, load = 0, use_mask = 0;
  logic [7:0] load_data = 0, refresh_mask = 0;
  logic [7:0] bus_q;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  decay_latch #(.WIDTH(8), .HOLD_TICKS(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load),
    .load_data(load_data), .use_mask(use_mask),
    .refresh_mask(refresh_mask), .bus_q(bus_q));

  // {req, ld, um, data, mask, ticks, expected}
  localparam logic [37:0] VEC [0:14] = '{
    {4'd2, 1'b1, 1'b0, 8'hFF, 8'h00, 8'd0,  8'hFF},  // R2
    {4'd4, 1'b0, 1'b0, 8'h00, 8'h00, 8'd20, 8'hFF},  // R4 last live tick
    {4'd4, 1'b0, 1'b0, 8'h00, 8'h00, 8'd1,  8'h00},  // R4 expiry
    {4'd2, 1'b1, 1'b0, 8'hA5, 8'h00, 8'd0,  8'hA5},  // R2
    {4'd3, 1'b1, 1'b0, 8'h00, 8'h00, 8'd5,  8'h00},  // R3
    {4'd4, 1'b1, 1'b0, 8'h0F, 8'h00, 8'd10, 8'h0F},  // R4
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'hF0, 8'd0,  8'hFF},  // R6
    {4'd5, 1'b0, 1'b0, 8'h00, 8'h00, 8'd10, 8'hFF},  // R5
    {4'd5, 1'b0, 1'b0, 8'h00, 8'h00, 8'd1,  8'hF0},  // R5 low nibble gone
    {4'd6, 1'b1, 1'b1, 8'hFF, 8'h00, 8'd0,  8'hF0},  // R6 expired stays 0
    {4'd5, 1'b0, 1'b0, 8'h00, 8'h00, 8'd9,  8'hF0},  // R5
    {4'd5, 1'b0, 1'b0, 8'h00, 8'h00, 8'd1,  8'h00},  // R5 high nibble gone
    {4'd2, 1'b1, 1'b0, 8'h3C, 8'h00, 8'd15, 8'h3C},  // R2
    {4'd9, 1'b1, 1'b0, 8'h3C, 8'h00, 8'd15, 8'h3C},  // R9 restart
    {4'd9, 1'b0, 1'b0, 8'h00, 8'h00, 8'd6,  8'h00}   // R9
  };

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (bus_q !== exp) begin
      bad++;
      $display("FAIL %s: bus_q=%02h expected=%02h", req, bus_q, exp);
    end
  endtask

  task automatic step(input logic ld, input logic um, input logic [7:0] d,
                      input logic [7:0] m, input logic tk);
    load = ld; use_mask = um; load_data = d; refresh_mask = m; tick_en = tk;
    @(posedge clk);
    @(negedge clk);
    load = 0; use_mask = 0; load_data = 0; refresh_mask = 0; tick_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 8'h00, 8'h00, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1", 8'h00);

    for (int r = 0; r < 15; r++) begin
      logic [37:0] v;
      v = VEC[r];
      if (v[33]) step(1, v[32], v[31:24], v[23:16], 0);
      ticks(int'(v[15:8]));
      check($sformatf("R%0d", v[37:34]), v[7:0]);
    end

    // R8: idle cycles without tick leave the value alone
    step(1, 0, 8'h81, 8'h00, 0);
    repeat (50) @(negedge clk);
    check("R8", 8'h81);

    // R7: load and tick together; bit0 refreshed, bit7 keeps ageing
    ticks(10);
    step(1, 1, 8'h81, 8'h01, 1);
    ticks(9);
    check("R7", 8'h81);
    ticks(1);
    check("R7", 8'h01);
    ticks(10);
    check("R7", 8'h01);
    ticks(1);
    check("R7", 8'h00);

    // R1: reset mid-run clears byte and timers
    step(1, 0, 8'hFF, 8'h00, 0);
    rst_n = 0;
    @(negedge clk);
    check("R1", 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1", 8'h00);
    step(1, 1, 8'hFF, 8'h00, 0);
    check("R1", 8'h00);

    finish_run();
  end
endmodule